// File: doc/BRIEF.md
# Configuration Byte-Lane Merge Unit

This unit sits between a big-endian requester and a bank of little-endian 32-bit configuration registers. The requester asks for one, two or four bytes at any byte offset within a dword. The register target only moves whole dwords. Byte 0 of the stored dword is bits [7:0] and byte 3 is bits [31:24]. Multi-byte accesses that run past byte 3 continue at byte 0 of the same dword. The bytes handed to or taken from the requester are in reversed order: the byte at the lowest address sits in the most significant position.

A read fetches the target dword once and returns the selected bytes, right-justified. A one- or two-byte write is a read-modify-write: the unit fetches the old dword, replaces only the addressed lanes and writes the full dword back. A four-byte write skips the fetch. Each response carries a flag that reports whether the access was misaligned. Requests with an unsupported size complete at once, return all ones and never reach the target.

Top module: `cfg_lane_merge`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid`, `tgt_rd_en` and `tgt_wr_en` are 0.
- R2: A read with size 1 at offset k returns stored byte k in `rsp_data[7:0]`, with bits [31:8] zero.
- R3: A read with size 2 at offset k returns byte k in bits [15:8] and byte (k+1) mod 4 in bits [7:0], with bits [31:16] zero, so that offset 3 pairs byte 3 with byte 0.
- R4: A read with size 4 at offset k returns bytes k, k+1, k+2, k+3 (mod 4), taken from bits [31:24] down to [7:0]; at offset 0 this is a full byte swap.
- R5: A write with size 1 or 2 first reads the target dword once. It then writes back a dword in which lane (k+j) mod 4 takes requester byte (size-1-j) of `req_wdata`, for each j below size, and every other lane keeps its old value.
- R6: A write with size 4 issues no target read. The dword written has lane (k+j) mod 4 equal to `req_wdata` byte (3-j).
- R7: A size other than 1, 2 or 4 completes with `rsp_data` all ones and performs no target read or write.
- R8: `rsp_misalign` is 1 exactly when the size is valid and (size-1) AND offset is nonzero.
- R9: `rsp_valid` is high for exactly one cycle per accepted request. `req_ready` is low from acceptance until one cycle after `rsp_valid`, and a `req_valid` seen while `req_ready` is low has no effect.
- R10: `tgt_rd_en` stays high until a cycle with `tgt_rd_valid`, and `tgt_wr_en` stays high with stable `tgt_wr_data` until a cycle with `tgt_wr_ack`. With target wait counts r and w, `rsp_valid` appears 2+r cycles after acceptance for a read, 3+r+w cycles for a narrow write and 2+w cycles for a full write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| req_offset | input | 2 | Byte offset within the dword |
| req_wdata | input | 32 | Write data, requester byte order, right-justified |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | 32 | Read result, or the dword written for writes |
| rsp_misalign | output | 1 | Misaligned-access flag, valid with rsp_valid |
| tgt_rd_en | output | 1 | Target dword read request |
| tgt_rd_valid | input | 1 | Target read data present |
| tgt_rd_data | input | 32 | Target dword read data |
| tgt_wr_en | output | 1 | Target dword write request |
| tgt_wr_ack | input | 1 | Target write accepted |
| tgt_wr_data | output | 32 | Merged dword to write |

## Verification
A narrow write puts two functions in one cycle. On the edge where the target's read data arrives, the old dword is captured and merged with the new bytes, and the write request goes up at once. A full write merges at acceptance, in the same cycle as the request handshake. The bench sets up a target model with no wait states, so that read return and merge coincide and write acknowledge follows on the next cycle. It then repeats the accesses with several wait counts. Each case is judged by the byte content of the target dword after the write and by the cycle on which `rsp_valid` appears.

// File: rtl/cfg_lane_pkg.sv
package cfg_lane_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int SIZE_W = OFF_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_STORE = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic                is_wr;
        logic [SIZE_W-1:0]   size;
        logic [OFF_W-1:0]    off;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   wr_word;
        logic [DATA_W-1:0]   rsp;
        logic                misal;
    } ctx_t;

    function automatic logic size_ok(input logic [SIZE_W-1:0] s);
        return (s == SIZE_W'(1)) || (s == SIZE_W'(2)) || (s == SIZE_W'(LANES));
    endfunction
endpackage

// File: rtl/cfg_lane_extract.sv
module cfg_lane_extract
    import cfg_lane_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [DATA_W-1:0] data_o
);
    logic [LANES-1:0][BYTE_W-1:0] pick;

    // result byte p comes from stored lane (off + size - 1 - p) mod LANES
    for (genvar p = 0; p < LANES; p++) begin : g_pick
        logic [BYTE_W-1:0] b;
        always_comb begin
            int src;
            src = (int'(off_i) + int'(size_i) - 1 - p) & (LANES - 1);
            b   = (p < int'(size_i)) ? word_i[src*BYTE_W +: BYTE_W] : '0;
        end
        assign pick[p] = b;
    end

    assign data_o = size_ok(size_i) ? pick : '1;
endmodule

// File: rtl/cfg_lane_insert.sv
module cfg_lane_insert
    import cfg_lane_pkg::*;
(
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] new_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [DATA_W-1:0] word_o
);
    logic [LANES-1:0][BYTE_W-1:0] lane;

    // stored lane L is the j-th requested byte, j = (L - off) mod LANES
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] b;
        always_comb begin
            int j;
            int idx;
            j   = (l - int'(off_i)) & (LANES - 1);
            idx = (int'(size_i) - 1 - j) & (LANES - 1);
            b   = (j < int'(size_i)) ? new_i[idx*BYTE_W +: BYTE_W]
                                     : old_i[l*BYTE_W +: BYTE_W];
        end
        assign lane[l] = b;
    end

    assign word_o = size_ok(size_i) ? lane : '1;
endmodule

// File: rtl/cfg_lane_merge.sv
module cfg_lane_merge
    import cfg_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_misalign,
    output logic              tgt_rd_en,
    input  logic              tgt_rd_valid,
    input  logic [DATA_W-1:0] tgt_rd_data,
    output logic              tgt_wr_en,
    input  logic              tgt_wr_ack,
    output logic [DATA_W-1:0] tgt_wr_data
);
    ctx_t c_q, c_d;

    logic              idle;
    logic [SIZE_W-1:0] ins_size;
    logic [OFF_W-1:0]  ins_off;
    logic [DATA_W-1:0] ins_new;
    logic [DATA_W-1:0] ins_word;
    logic [DATA_W-1:0] ext_word;
    logic              req_misal;

    assign idle     = (c_q.phase == PH_IDLE);
    assign ins_size = idle ? req_size   : c_q.size;
    assign ins_off  = idle ? req_offset : c_q.off;
    assign ins_new  = idle ? req_wdata  : c_q.wdata;

    cfg_lane_extract u_extract (
        .word_i (tgt_rd_data),
        .size_i (c_q.size),
        .off_i  (c_q.off),
        .data_o (ext_word)
    );

    cfg_lane_insert u_insert (
        .old_i  (tgt_rd_data),
        .new_i  (ins_new),
        .size_i (ins_size),
        .off_i  (ins_off),
        .word_o (ins_word)
    );

    assign req_misal = size_ok(req_size) &&
                       ((SIZE_W'(req_size - SIZE_W'(1)) & SIZE_W'(req_offset)) != '0);

    always_comb begin
        c_d = c_q;
        unique case (c_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    c_d.is_wr = req_write;
                    c_d.size  = req_size;
                    c_d.off   = req_offset;
                    c_d.wdata = req_wdata;
                    c_d.misal = req_misal;
                    if (!size_ok(req_size)) begin
                        c_d.rsp   = '1;
                        c_d.phase = PH_DONE;
                    end else if (req_write && (req_size == SIZE_W'(LANES))) begin
                        c_d.wr_word = ins_word;
                        c_d.phase   = PH_STORE;
                    end else begin
                        c_d.phase = PH_FETCH;
                    end
                end
            end
            PH_FETCH: begin
                if (tgt_rd_valid) begin
                    if (c_q.is_wr) begin
                        c_d.wr_word = ins_word;
                        c_d.phase   = PH_STORE;
                    end else begin
                        c_d.rsp   = ext_word;
                        c_d.phase = PH_DONE;
                    end
                end
            end
            PH_STORE: begin
                if (tgt_wr_ack) begin
                    c_d.rsp   = c_q.wr_word;
                    c_d.phase = PH_DONE;
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign req_ready    = idle;
    assign tgt_rd_en    = (c_q.phase == PH_FETCH);
    assign tgt_wr_en    = (c_q.phase == PH_STORE);
    assign tgt_wr_data  = c_q.wr_word;
    assign rsp_valid    = (c_q.phase == PH_DONE);
    assign rsp_data     = c_q.rsp;
    assign rsp_misalign = c_q.misal;

    // ---------------- assertions ----------------
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd_en || tgt_wr_en || rsp_valid) |-> !req_ready);

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd_en && !tgt_rd_valid) |=> tgt_rd_en);

    p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr_en && !tgt_wr_ack) |=> (tgt_wr_en && $stable(tgt_wr_data)));

    p_full_wr_no_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_en |-> !(c_q.is_wr && (c_q.size == SIZE_W'(LANES))));

    p_narrow_fetch_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tgt_wr_en) && (c_q.size != SIZE_W'(LANES))) |-> $past(tgt_rd_en));

    p_bad_size_no_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rd_en || tgt_wr_en) |-> size_ok(c_q.size));

    p_byte_never_misal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (c_q.size == SIZE_W'(1))) |-> !rsp_misalign);
endmodule

// File: tb/cfg_lane_merge_bench.sv
module cfg_lane_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [2:0]  req_size = 3'd0;
    logic [1:0]  req_offset = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_misalign;
    logic        tgt_rd_en;
    logic        tgt_rd_valid = 1'b0;
    logic [31:0] tgt_rd_data = 32'hDEAD_BEEF;
    logic        tgt_wr_en;
    logic        tgt_wr_ack = 1'b0;
    logic [31:0] tgt_wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [31:0] tgt_mem = '0;
    int rd_lat = 0, wr_lat = 0, rd_wait = 0, wr_wait = 0;
    int n_rd = 0, n_wr = 0;

    always #2.5 clk = ~clk;

    cfg_lane_merge u_cfg_lane_merge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_misalign(rsp_misalign),
        .tgt_rd_en(tgt_rd_en), .tgt_rd_valid(tgt_rd_valid), .tgt_rd_data(tgt_rd_data),
        .tgt_wr_en(tgt_wr_en), .tgt_wr_ack(tgt_wr_ack), .tgt_wr_data(tgt_wr_data)
    );

    // target model: one dword, programmable wait counts, driven at negedge
    always @(negedge clk) begin
        tgt_rd_valid = 1'b0;
        tgt_rd_data  = 32'hDEAD_BEEF;
        tgt_wr_ack   = 1'b0;
        if (rst_n && tgt_rd_en) begin
            if (rd_wait >= rd_lat) begin
                tgt_rd_valid = 1'b1; tgt_rd_data = tgt_mem; n_rd++; rd_wait = 0;
            end else rd_wait++;
        end
        if (rst_n && tgt_wr_en) begin
            if (wr_wait >= wr_lat) begin
                tgt_wr_ack = 1'b1; tgt_mem = tgt_wr_data; n_wr++; wr_wait = 0;
            end else wr_wait++;
        end
    end

    function automatic logic [31:0] m_read(logic [31:0] dw, int size, int off);
        logic [31:0] r = '0;
        if (size != 1 && size != 2 && size != 4) return 32'hFFFF_FFFF;
        for (int n = 0; n < size; n++) r = (r << 8) | 32'(dw[8*((off+n)%4) +: 8]);
        return r;
    endfunction

    function automatic logic [31:0] m_write(logic [31:0] old, logic [31:0] nd, int size, int off);
        logic [7:0] b[4];
        for (int i = 0; i < 4; i++) b[i] = old[8*i +: 8];
        for (int n = 0; n < size; n++) b[(off+n)%4] = 8'(nd >> (8*(size-1-n)));
        return {b[3], b[2], b[1], b[0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic w, input int size, input int off, input logic [31:0] wd,
                             output logic [31:0] rsp, output logic mis, output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = 3'(size);
        req_offset = 2'(off); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 60) begin @(negedge clk); cyc++; end
        rsp = rsp_data; mis = rsp_misalign;
        @(negedge clk);
        check("R9 strobe one cycle", 32'(rsp_valid), 32'd0);
        check("R9 ready after done", 32'(req_ready), 32'd1);
    endtask

    task automatic t_reset;
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 rd_en", 32'(tgt_rd_en), 32'd0);
        check("R1 wr_en", 32'(tgt_wr_en), 32'd0);
    endtask

    task automatic t_reads;
        logic [31:0] r; logic m; int c;
        tgt_mem = 32'h4433_2211; rd_lat = 1;
        for (int off = 0; off < 4; off++) begin
            do_access(1'b0, 1, off, '0, r, m, c);
            check($sformatf("R2 byte read off %0d", off), r, m_read(tgt_mem, 1, off));
            check("R8 byte never misaligned", 32'(m), 32'd0);
            do_access(1'b0, 2, off, '0, r, m, c);
            check($sformatf("R3 word read off %0d", off), r, m_read(tgt_mem, 2, off));
            check("R8 word misalign", 32'(m), 32'(off % 2));
            do_access(1'b0, 4, off, '0, r, m, c);
            check($sformatf("R4 dword read off %0d", off), r, m_read(tgt_mem, 4, off));
            check("R8 dword misalign", 32'(m), 32'(off != 0));
        end
        do_access(1'b0, 2, 3, '0, r, m, c);
        check("R3 wrap pairs byte3 with byte0", r, 32'h0000_4411);
        do_access(1'b0, 4, 0, '0, r, m, c);
        check("R4 full swap at offset 0", r, 32'h1122_3344);
    endtask

    task automatic t_narrow_writes;
        logic [31:0] r, old; logic m; int c, rd0;
        rd_lat = 2; wr_lat = 1;
        for (int sz = 1; sz <= 2; sz++)
            for (int off = 0; off < 4; off++) begin
                tgt_mem = 32'hA0B0_C0D0; old = tgt_mem; rd0 = n_rd;
                do_access(1'b1, sz, off, 32'h0000_125A, r, m, c);
                check($sformatf("R5 merge size %0d off %0d", sz, off), tgt_mem,
                      m_write(old, 32'h0000_125A, sz, off));
                check("R5 one fetch", 32'(n_rd - rd0), 32'd1);
            end
        tgt_mem = 32'hA0B0_C0D0;
        do_access(1'b1, 2, 3, 32'h0000_1234, r, m, c);
        check("R5 wrapped word write", tgt_mem, 32'h12B0_C034);
        check("R8 wrapped word write misaligned", 32'(m), 32'd1);
    endtask

    task automatic t_full_writes;
        logic [31:0] r; logic m; int c, rd0;
        for (int off = 0; off < 4; off++) begin
            tgt_mem = 32'h5555_5555; rd0 = n_rd;
            do_access(1'b1, 4, off, 32'h0102_0304, r, m, c);
            check($sformatf("R6 full write off %0d", off), tgt_mem,
                  m_write(32'h5555_5555, 32'h0102_0304, 4, off));
            check("R6 no fetch", 32'(n_rd - rd0), 32'd0);
        end
        tgt_mem = '0;
        do_access(1'b1, 4, 1, 32'h0102_0304, r, m, c);
        check("R6 rotated lanes", tgt_mem, 32'h0302_0104);
    endtask

    task automatic t_bad_size;
        logic [31:0] r; logic m; int c, rd0, wr0;
        tgt_mem = 32'h1357_9BDF; rd0 = n_rd; wr0 = n_wr;
        do_access(1'b0, 3, 1, '0, r, m, c);
        check("R7 bad read all ones", r, 32'hFFFF_FFFF);
        do_access(1'b1, 0, 0, 32'h0000_00AA, r, m, c);
        check("R7 bad write all ones", r, 32'hFFFF_FFFF);
        check("R7 target untouched", tgt_mem, 32'h1357_9BDF);
        check("R7 no target reads", 32'(n_rd - rd0), 32'd0);
        check("R7 no target writes", 32'(n_wr - wr0), 32'd0);
        check("R8 bad size not misaligned", 32'(m), 32'd0);
    endtask

    task automatic t_timing;
        logic [31:0] r; logic m; int c;
        for (int lat = 0; lat < 4; lat += 3) begin
            rd_lat = lat; wr_lat = lat; tgt_mem = 32'h0F1E_2D3C;
            do_access(1'b0, 4, 2, '0, r, m, c);
            check($sformatf("R10 read latency %0d", lat), 32'(c), 32'(2 + lat));
            do_access(1'b1, 1, 1, 32'h0000_0077, r, m, c);
            check($sformatf("R10 narrow write latency %0d", lat), 32'(c), 32'(3 + 2*lat));
            check("R5 merge under same-cycle capture", tgt_mem, 32'h0F1E_773C);
            do_access(1'b1, 4, 0, 32'hCAFE_F00D, r, m, c);
            check($sformatf("R10 full write latency %0d", lat), 32'(c), 32'(2 + lat));
            check("R6 full write data", r, 32'h0DF0_FECA);
        end
    endtask

    task automatic t_busy_ignore;
        int wr0;
        rd_lat = 4; wr_lat = 0; tgt_mem = 32'h2468_ACE0; wr0 = n_wr;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 3'd4; req_offset = 2'd0;
        @(negedge clk);
        req_write = 1'b1; req_wdata = 32'h9999_9999;  // held high while busy
        while (!rsp_valid) @(negedge clk);
        req_valid = 1'b0;
        check("R4 read during stray request", rsp_data, 32'hE0AC_6824);
        repeat (6) @(negedge clk);
        check("R9 stray request ignored", tgt_mem, 32'h2468_ACE0);
        check("R9 no stray write", 32'(n_wr - wr0), 32'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_narrow_writes();
        t_full_writes();
        t_bad_size();
        t_timing();
        t_busy_ignore();
        finish_run();
    end
endmodule